// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block is a purely combinational unsigned adder. It takes two operands and a carry-in, and it returns their sum together with a carry-out. The carries are not produced by a chain that ripples from bit to bit. Each bit forms a propagate term and a generate term. These are gathered into fixed-size groups, and each group resolves its internal carries as a flat sum of products. Each group also reports one propagate and one generate for the group as a whole.

A second lookahead unit uses the group terms in the same two-level product form. From them it derives the carry into every group boundary and the final carry-out. This keeps the carry depth at about four gate levels for the default 16-bit width, where a ripple chain would need a number of levels that grows with the width. A surrounding datapath places the adder between its registers and reads the result in the same cycle.

The width and the group size are parameters. The defaults are a 16-bit operand width and four groups of four bits.

Top module: `hier_cla_adder`

## Requirements
- R1: For every input combination, the 17-bit value {carry_out, sum_out} equals opnd_a + opnd_b + carry_in, with both operands unsigned.
- R2: Sum bit i equals opnd_a[i] XOR opnd_b[i] XOR the carry into bit i. When no carries arise anywhere (carry_in = 0 and no bit has both operand bits set), sum_out equals opnd_a XOR opnd_b.
- R3: A group's propagate is true exactly when every bit in the group has opnd_a[i] differing from opnd_b[i]. When opnd_b = ~opnd_a, every group propagates: carry_in = 1 gives sum_out = 0 with carry_out = 1, and carry_in = 0 gives all ones with carry_out = 0.
- R4: A group's generate is true exactly when the group's own bits, added with a carry-in of 0, produce a carry out of the group. Such a carry reaches the next group whatever the value of carry_in.
- R5: The carry into group k (bit position k*GROUP) equals the carry out of adding the bits below that position together with carry_in.
- R6: carry_out is formed by the second-level unit from the group propagate and generate terms and carry_in. All ones plus a carry-in of 1 gives sum_out = 0 and carry_out = 1.
- R7: The block holds no state. Outputs follow any change of the inputs without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH (16) | First unsigned operand |
| opnd_b | input | WIDTH (16) | Second unsigned operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | WIDTH (16) | Sum bits |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
The bench builds the adder with its default parameters, WIDTH = 16 and GROUP = 4. This gives four groups, so the second-level unit uses every product term it has, up to a generate in group 0 travelling through three propagating groups. Directed vectors aim at the group edges: full propagate chains, a generate confined to one group, and all ones plus one. Seeded random vectors cover the mixed cases, and each one is compared with a plain 17-bit sum computed in the bench.

// File: rtl/cla_pkg.sv
// Package cla_pkg
// Holds the types shared by the lookahead adder modules.
// Assumes: nothing beyond a standard SystemVerilog compile.
package cla_pkg;

    // Default geometry of the adder.
    localparam int unsigned DEF_WIDTH = 16;
    localparam int unsigned DEF_GROUP = 4;

    // Propagate/generate pair that a span of bits reports upward.
    typedef struct packed {
        logic prop;
        logic gen;
    } pg_t;

endpackage

// File: rtl/cla_bit_cell.sv
// Module cla_bit_cell
// One bit slice. It forms the bit propagate (XOR) and the bit generate (AND),
// and it returns the sum bit once the carry into this bit is known.
// Assumes: the carry into the bit comes from a lookahead unit, not from a neighbour.
module cla_bit_cell (
    input  logic bit_a,
    input  logic bit_b,
    input  logic bit_cin,
    output logic bit_p,
    output logic bit_g,
    output logic bit_s
);

    // Bit propagate/generate and sum.
    always_comb begin
        bit_p = bit_a ^ bit_b;
        bit_g = bit_a & bit_b;
        bit_s = bit_p ^ bit_cin;
    end

endmodule

// File: rtl/cla_lookahead.sv
// Module cla_lookahead
// Flat two-level lookahead over N propagate/generate pairs.
// Carry into position i is an OR of products: each lower generate ANDed with
// every propagate above it and below i, plus the carry-in ANDed with all
// propagates below i. It also reports the span propagate and span generate.
// Assumes: N is small (a few), since the product terms grow as N squared.
module cla_lookahead #(
    parameter int unsigned N = 4
) (
    input  logic           [N-1:0] span_p,
    input  logic           [N-1:0] span_g,
    input  logic                   span_cin,
    output logic           [N-1:0] pos_carry,
    output cla_pkg::pg_t           span_pg
);

    // Carry into each position as a sum of products.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            logic acc;
            acc = span_cin;
            for (int k = 0; k < i; k++) acc = acc & span_p[k];
            for (int j = 0; j < i; j++) begin
                logic term;
                term = span_g[j];
                for (int k = j + 1; k < i; k++) term = term & span_p[k];
                acc = acc | term;
            end
            pos_carry[i] = acc;
        end
    end

    // Span propagate (all bits pass) and span generate (carry made inside).
    always_comb begin
        logic pp;
        logic gg;
        pp = 1'b1;
        gg = 1'b0;
        for (int k = 0; k < N; k++) pp = pp & span_p[k];
        for (int j = 0; j < N; j++) begin
            logic term;
            term = span_g[j];
            for (int k = j + 1; k < N; k++) term = term & span_p[k];
            gg = gg | term;
        end
        span_pg.prop = pp;
        span_pg.gen  = gg;
    end

endmodule

// File: rtl/cla_group.sv
// Module cla_group
// One lookahead group of GROUP bits: bit cells plus a local lookahead unit.
// It exports the group propagate/generate for the second level and takes the
// carry into the group from that level.
// Assumes: grp_cin is the carry into the group's lowest bit.
module cla_group #(
    parameter int unsigned GROUP = 4
) (
    input  logic           [GROUP-1:0] grp_a,
    input  logic           [GROUP-1:0] grp_b,
    input  logic                       grp_cin,
    output logic           [GROUP-1:0] grp_sum,
    output cla_pkg::pg_t               grp_pg
);

    logic [GROUP-1:0] bp;
    logic [GROUP-1:0] bg;
    logic [GROUP-1:0] bc;

    // One bit cell for each bit of the group.
    for (genvar i = 0; i < GROUP; i++) begin : g_bit
        cla_bit_cell u_cell (
            .bit_a  (grp_a[i]),
            .bit_b  (grp_b[i]),
            .bit_cin(bc[i]),
            .bit_p  (bp[i]),
            .bit_g  (bg[i]),
            .bit_s  (grp_sum[i])
        );
    end

    cla_lookahead #(.N(GROUP)) u_local (
        .span_p   (bp),
        .span_g   (bg),
        .span_cin (grp_cin),
        .pos_carry(bc),
        .span_pg  (grp_pg)
    );

endmodule

// File: rtl/hier_cla_adder.sv
// Module hier_cla_adder
// Unsigned adder, WIDTH bits, built from WIDTH/GROUP lookahead groups and a
// second-level lookahead unit that drives each group's carry-in. The carry-out
// comes from the second-level span terms and the carry-in.
// Assumes: WIDTH is a multiple of GROUP. No clock, no reset: purely combinational.
module hier_cla_adder #(
    parameter int unsigned WIDTH = cla_pkg::DEF_WIDTH,
    parameter int unsigned GROUP = cla_pkg::DEF_GROUP
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out
);

    localparam int unsigned NGRP = WIDTH / GROUP;

    cla_pkg::pg_t     grp_pg [NGRP];
    cla_pkg::pg_t     top_pg;
    logic [NGRP-1:0]  grp_prop;
    logic [NGRP-1:0]  grp_gen;
    logic [NGRP-1:0]  grp_carry;

    // One group instance for each GROUP-bit slice.
    for (genvar k = 0; k < NGRP; k++) begin : g_grp
        cla_group #(.GROUP(GROUP)) u_group (
            .grp_a  (opnd_a[k*GROUP +: GROUP]),
            .grp_b  (opnd_b[k*GROUP +: GROUP]),
            .grp_cin(grp_carry[k]),
            .grp_sum(sum_out[k*GROUP +: GROUP]),
            .grp_pg (grp_pg[k])
        );
        assign grp_prop[k] = grp_pg[k].prop;
        assign grp_gen[k]  = grp_pg[k].gen;
    end

    // Second level: carries into every group boundary.
    cla_lookahead #(.N(NGRP)) u_upper (
        .span_p   (grp_prop),
        .span_g   (grp_gen),
        .span_cin (carry_in),
        .pos_carry(grp_carry),
        .span_pg  (top_pg)
    );

    // Final carry from the second-level span terms.
    assign carry_out = top_pg.gen | (top_pg.prop & carry_in);

endmodule

// File: rtl/hier_cla_adder_chk.sv
// Module hier_cla_adder_chk
// Checker bound to hier_cla_adder. It compares the group terms and the
// boundary carries with plain arithmetic on the operand slices.
// Assumes: combinational inputs have settled when the always_comb runs.
module hier_cla_adder_chk #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned GROUP = 4
) (
    input logic [WIDTH-1:0]       opnd_a,
    input logic [WIDTH-1:0]       opnd_b,
    input logic                   carry_in,
    input logic [WIDTH-1:0]       sum_out,
    input logic                   carry_out,
    input logic [WIDTH/GROUP-1:0] grp_prop,
    input logic [WIDTH/GROUP-1:0] grp_gen,
    input logic [WIDTH/GROUP-1:0] grp_carry
);

    localparam int unsigned NGRP = WIDTH / GROUP;

    // Full result and the per-group terms against arithmetic.
    always_comb begin
        logic [WIDTH:0] full;
        full = {1'b0, opnd_a} + {1'b0, opnd_b} + {{WIDTH{1'b0}}, carry_in};
        p_full_sum_r1: assert ({carry_out, sum_out} == full)
            else $error("R1 sum mismatch");
        p_no_carry_sum_r2: assert (!(carry_in == 1'b0 && (opnd_a & opnd_b) == '0)
                                   || sum_out == (opnd_a ^ opnd_b))
            else $error("R2 carry-free sum mismatch");
        for (int k = 0; k < NGRP; k++) begin
            logic [GROUP-1:0] sa;
            logic [GROUP-1:0] sb;
            logic [GROUP:0]   gsum;
            logic [WIDTH:0]   mask;
            logic [WIDTH:0]   low;
            sa   = opnd_a[k*GROUP +: GROUP];
            sb   = opnd_b[k*GROUP +: GROUP];
            gsum = {1'b0, sa} + {1'b0, sb};
            mask = ({{WIDTH{1'b0}}, 1'b1} << (k*GROUP)) - 1'b1;
            low  = ({1'b0, opnd_a} & mask) + ({1'b0, opnd_b} & mask)
                   + {{WIDTH{1'b0}}, carry_in};
            p_grp_prop_r3: assert (grp_prop[k] == ((sa ^ sb) == {GROUP{1'b1}}))
                else $error("R3 group propagate mismatch");
            p_grp_gen_r4: assert (grp_gen[k] == gsum[GROUP])
                else $error("R4 group generate mismatch");
            p_grp_carry_r5: assert (grp_carry[k] == low[k*GROUP])
                else $error("R5 group carry mismatch");
        end
    end

    // Carry-out from the group terms.
    always_comb begin
        logic chain;
        chain = carry_in;
        for (int k = 0; k < NGRP; k++) chain = grp_gen[k] | (grp_prop[k] & chain);
        p_cout_chain_r6: assert (carry_out == chain)
            else $error("R6 carry-out mismatch");
    end

endmodule

bind hier_cla_adder hier_cla_adder_chk #(.WIDTH(WIDTH), .GROUP(GROUP)) u_chk (
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .carry_in (carry_in),
    .sum_out  (sum_out),
    .carry_out(carry_out),
    .grp_prop (grp_prop),
    .grp_gen  (grp_gen),
    .grp_carry(grp_carry)
);

// File: tb/hier_cla_adder_tb.sv
// Bench for hier_cla_adder: directed corner cases plus seeded random vectors.
// Results are compared against a 17-bit reference sum computed in the bench.
module hier_cla_adder_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WIDTH      = 16;
    localparam int MAX_CYCLES = 100000;
    localparam int N_RANDOM   = 2000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [WIDTH-1:0] a = '0;
    logic [WIDTH-1:0] b = '0;
    logic             cin = 1'b0;
    logic [WIDTH-1:0] sum;
    logic             cout;
    int               checks = 0;
    int               failures = 0;
    int               cycles = 0;
    bit               done = 1'b0;

    hier_cla_adder #(.WIDTH(WIDTH), .GROUP(4)) u_dut (
        .opnd_a   (a),
        .opnd_b   (b),
        .carry_in (cin),
        .sum_out  (sum),
        .carry_out(cout)
    );

    // Free-running bench clock.
    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference result from the requirements: plain unsigned addition.
    function automatic logic [WIDTH:0] ref_sum(input logic [WIDTH-1:0] x,
                                               input logic [WIDTH-1:0] y,
                                               input logic c);
        return {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, c};
    endfunction

    // Compare one observed value with its expected value.
    task automatic check(input string req, input logic [WIDTH:0] got,
                         input logic [WIDTH:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h expected=%h", req, got, exp);
        end
    endtask

    // Drive operands at a falling edge, sample shortly after, then check.
    task automatic apply(input logic [WIDTH-1:0] x, input logic [WIDTH-1:0] y,
                         input logic c, input string req);
        @(negedge clk);
        a = x; b = y; cin = c;
        #1;
        check(req, {cout, sum}, ref_sum(x, y, c));
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        while (!done && cycles < MAX_CYCLES) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            failures++;
            $display("FAIL watchdog got=%0d expected<%0d", cycles, MAX_CYCLES);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Main stimulus sequence.
    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Zero inputs: zero outputs (R1).
        #1;
        check("R1 zero inputs", {cout, sum}, '0);
        // R7: output follows an input change with no clock edge.
        @(negedge clk);
        #2;
        a = 16'h1234; b = 16'h0F0F;
        #1;
        check("R7 combinational follow", {cout, sum}, ref_sum(16'h1234, 16'h0F0F, 1'b0));
        // R2: no carries anywhere, sum is the XOR of the operands.
        apply(16'hA5A5, 16'h5050, 1'b0, "R2 carry-free");
        @(negedge clk); #1;
        check("R2 xor form", {1'b0, sum}, {1'b0, 16'hA5A5 ^ 16'h5050});
        // R3: full propagate chain, carry-in travels to carry-out.
        apply(16'h1234, 16'hEDCB, 1'b1, "R3 propagate cin=1");
        check("R3 wrap to zero", {cout, sum}, 17'h1_0000);
        apply(16'h1234, 16'hEDCB, 1'b0, "R3 propagate cin=0");
        check("R3 all ones", {cout, sum}, 17'h0_FFFF);
        // R4: a generate in group 0 reaches group 1 regardless of carry_in.
        apply(16'h000F, 16'h0001, 1'b0, "R4 gen group0 cin=0");
        check("R4 value", {cout, sum}, 17'h0_0010);
        apply(16'h000F, 16'h0001, 1'b1, "R4 gen group0 cin=1");
        // R5: generate in group 0 through propagating groups 1 and 2.
        apply(16'h0FF8, 16'h0008, 1'b0, "R5 boundary carry");
        check("R5 value", {cout, sum}, 17'h0_1000);
        apply(16'h7FFF, 16'h0001, 1'b0, "R5 into top group");
        // R6: all ones plus carry-in and plus one.
        apply(16'hFFFF, 16'h0000, 1'b1, "R6 ones plus cin");
        check("R6 value", {cout, sum}, 17'h1_0000);
        apply(16'hFFFF, 16'h0001, 1'b0, "R6 ones plus one");
        apply(16'hFFFF, 16'hFFFF, 1'b1, "R6 max inputs");
        check("R6 max value", {cout, sum}, 17'h1_FFFF);
        // R1: seeded random vectors.
        for (int n = 0; n < N_RANDOM; n++) begin
            logic [WIDTH-1:0] x;
            logic [WIDTH-1:0] y;
            logic             c;
            x = WIDTH'($urandom);
            y = WIDTH'($urandom);
            c = 1'($urandom);
            if (n % 4 == 0) y = ~x;
            apply(x, y, c, "R1 random");
        end
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule